// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This block steps a serial-link controller through start-up in two phases. A start pulse writes the lowest speed limit (generation 1) to the controller, then enables link training and polls the link-up indication at a fixed, parameterised interval. Once the link is up, the block raises the speed limit to generation 2 and requests a directed speed change. It then polls a busy flag until the change completes, and finally checks link-up once more.

Each of the three waits has the same poll budget. If a budget runs out, the sequence stops with a fail flag. On success the block sets a done flag and captures the negotiated generation from a status word. Done and fail are sticky until the next start. A start pulse that arrives while a sequence is running is ignored.

Top module: `link_speed_seq`

## Requirements
- R1: After reset, maxSpeed is 1, and trainEn, speedChgReq, done, fail and finalGen are all 0.
- R2: When no sequence is running, a start pulse sets maxSpeed to 1, drops trainEn and clears done and fail one cycle later. trainEn rises one cycle after that.
- R3: linkUp is first polled one cycle after trainEn rises, and again every POLL_GAP+1 cycles, for at most MAX_POLLS polls. A link seen on the last poll still counts. Otherwise fail rises exactly 1+(MAX_POLLS-1)*(POLL_GAP+1) cycles after trainEn rises.
- R4: In the cycle that follows a successful first link poll, maxSpeed becomes 2 and speedChgReq becomes 1.
- R5: speedBusy is first polled POLL_GAP+1 cycles after speedChgReq rises, and again every POLL_GAP+1 cycles, for at most MAX_POLLS polls. A poll that sees speedBusy at 0 clears speedChgReq. If every poll sees it at 1, fail rises MAX_POLLS*(POLL_GAP+1) cycles after speedChgReq rose.
- R6: After the speed change, linkUp is polled again under the same poll budget. If the link never comes back, the sequence ends in fail.
- R7: A successful second link poll sets done and loads finalGen from linkStatus bits [19:16] in the same cycle.
- R8: done and fail stay set until the next start. A start pulse that arrives while a sequence is running has no effect.
- R9: On a failure, trainEn stays 1, maxSpeed keeps its value and speedChgReq is 0.
- R10: done and fail are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for a new bring-up |
| linkUp | input | 1 | Link-up indication from the controller |
| speedBusy | input | 1 | Directed speed change still in progress |
| linkStatus | input | 32 | Link status word; bits [19:16] hold the negotiated generation |
| maxSpeed | output | 4 | Maximum link speed limit driven to the controller |
| trainEn | output | 1 | Link training enable |
| speedChgReq | output | 1 | Directed speed change request |
| done | output | 1 | Sequence finished with the link up |
| fail | output | 1 | A poll budget ran out |
| finalGen | output | 4 | Negotiated generation captured on success |

## Verification
The bench keeps MAX_POLLS at 200 and sets POLL_GAP to 3, so one poll window is 4 cycles and a complete timeout takes roughly 800 cycles. With these values the exact cycle of each timeout can be counted, and the bench drives linkUp one cycle before and one cycle after the final poll. The full poll budget is therefore exercised while runs stay short. The bench also holds speedBusy high across several polls, drops the link after the speed change, and pulses start in the middle of a wait.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LINK1, ST_CHG, ST_LINK2, ST_DONE, ST_FAIL
  } seqState_t;

  typedef struct packed {
    logic clrRun;
    logic enTrain;
    logic raiseSpeed;
    logic clrReq;
    logic latchGen;
    logic setDone;
    logic setFail;
    logic pollRst;
    logic gapLoad;
    logic pollMiss;
  } ctlStrobes_t;
endpackage

// File: rtl/lss_datapath.sv
module lss_datapath
  import lss_pkg::*;
#(
  parameter int SPEED_W   = 4,
  parameter int GEN_W     = 4,
  parameter int STAT_W    = 32,
  parameter int GEN_LSB   = 16,
  parameter int LOW_GEN   = 1,
  parameter int HIGH_GEN  = 2,
  parameter int MAX_POLLS = 200,
  parameter int POLL_GAP  = 12500
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        stb,
  input  logic [STAT_W-1:0]  linkStatus,
  output logic               pollDue,
  output logic               pollLast,
  output logic [SPEED_W-1:0] maxSpeed,
  output logic               trainEn,
  output logic               speedChgReq,
  output logic               done,
  output logic               fail,
  output logic [GEN_W-1:0]   finalGen
);
  localparam int PC_W = $clog2(MAX_POLLS + 1);
  localparam int WC_W = $clog2(POLL_GAP + 2);
  localparam logic [SPEED_W-1:0] SPD_LOW  = SPEED_W'(LOW_GEN);
  localparam logic [SPEED_W-1:0] SPD_HIGH = SPEED_W'(HIGH_GEN);
  localparam logic [WC_W-1:0]    GAP      = WC_W'(POLL_GAP);
  localparam logic [PC_W-1:0]    LASTPOLL = PC_W'(MAX_POLLS - 1);

  logic [PC_W-1:0] pollCnt;
  logic [WC_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxSpeed    <= SPD_LOW;
      trainEn     <= 1'b0;
      speedChgReq <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      finalGen    <= '0;
    end else begin
      if (stb.clrRun) begin
        maxSpeed    <= SPD_LOW;
        trainEn     <= 1'b0;
        speedChgReq <= 1'b0;
        done        <= 1'b0;
        fail        <= 1'b0;
      end
      if (stb.enTrain) trainEn <= 1'b1;
      if (stb.raiseSpeed) begin
        maxSpeed    <= SPD_HIGH;
        speedChgReq <= 1'b1;
      end
      if (stb.clrReq)   speedChgReq <= 1'b0;
      if (stb.latchGen) finalGen <= linkStatus[GEN_LSB +: GEN_W];
      if (stb.setDone)  done <= 1'b1;
      if (stb.setFail)  fail <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
      waitCnt <= '0;
    end else if (stb.pollRst) begin
      pollCnt <= '0;
      waitCnt <= stb.gapLoad ? GAP : '0;
    end else if (stb.pollMiss) begin
      pollCnt <= pollCnt + 1'b1;
      waitCnt <= GAP;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign pollDue  = (waitCnt == '0);
  assign pollLast = (pollCnt == LASTPOLL);
endmodule

// File: rtl/lss_control.sv
module lss_control
  import lss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        linkUp,
  input  logic        speedBusy,
  input  logic        pollDue,
  input  logic        pollLast,
  output ctlStrobes_t stb
);
  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          stb.clrRun = 1'b1;
          nxt = ST_ARM;
        end
      end
      ST_ARM: begin
        stb.enTrain = 1'b1;
        stb.pollRst = 1'b1;
        nxt = ST_LINK1;
      end
      ST_LINK1: begin
        if (pollDue) begin
          if (linkUp) begin
            stb.raiseSpeed = 1'b1;
            stb.pollRst    = 1'b1;
            stb.gapLoad    = 1'b1;
            nxt = ST_CHG;
          end else if (pollLast) begin
            stb.setFail = 1'b1;
            nxt = ST_FAIL;
          end else begin
            stb.pollMiss = 1'b1;
          end
        end
      end
      ST_CHG: begin
        if (pollDue) begin
          if (!speedBusy) begin
            stb.clrReq  = 1'b1;
            stb.pollRst = 1'b1;
            nxt = ST_LINK2;
          end else if (pollLast) begin
            stb.clrReq  = 1'b1;
            stb.setFail = 1'b1;
            nxt = ST_FAIL;
          end else begin
            stb.pollMiss = 1'b1;
          end
        end
      end
      ST_LINK2: begin
        if (pollDue) begin
          if (linkUp) begin
            stb.latchGen = 1'b1;
            stb.setDone  = 1'b1;
            nxt = ST_DONE;
          end else if (pollLast) begin
            stb.setFail = 1'b1;
            nxt = ST_FAIL;
          end else begin
            stb.pollMiss = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
  import lss_pkg::*;
#(
  parameter int SPEED_W   = 4,
  parameter int GEN_W     = 4,
  parameter int STAT_W    = 32,
  parameter int GEN_LSB   = 16,
  parameter int MAX_POLLS = 200,
  parameter int POLL_GAP  = 12500
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               linkUp,
  input  logic               speedBusy,
  input  logic [STAT_W-1:0]  linkStatus,
  output logic [SPEED_W-1:0] maxSpeed,
  output logic               trainEn,
  output logic               speedChgReq,
  output logic               done,
  output logic               fail,
  output logic [GEN_W-1:0]   finalGen
);
  ctlStrobes_t stb;
  logic pollDue, pollLast;

  lss_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .linkUp(linkUp),
    .speedBusy(speedBusy), .pollDue(pollDue), .pollLast(pollLast), .stb(stb)
  );

  lss_datapath #(
    .SPEED_W(SPEED_W), .GEN_W(GEN_W), .STAT_W(STAT_W), .GEN_LSB(GEN_LSB),
    .LOW_GEN(1), .HIGH_GEN(2), .MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .linkStatus(linkStatus),
    .pollDue(pollDue), .pollLast(pollLast), .maxSpeed(maxSpeed),
    .trainEn(trainEn), .speedChgReq(speedChgReq), .done(done),
    .fail(fail), .finalGen(finalGen)
  );
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int SPEED_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               linkUp,
  input logic               speedBusy,
  input logic [SPEED_W-1:0] maxSpeed,
  input logic               trainEn,
  input logic               speedChgReq,
  input logic               done,
  input logic               fail
);
  // R10
  a_r10_done_fail_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));
  // R2: training only starts once the low limit is in place
  a_r2_train_after_limit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trainEn) |-> $past(maxSpeed) == SPEED_W'(1));
  // R4
  a_r4_req_with_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(speedChgReq) |-> (maxSpeed == SPEED_W'(2)) && trainEn);
  // R5
  a_r5_req_clear_on_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(speedChgReq) && !fail) |-> !$past(speedBusy));
  // R7
  a_r7_done_after_link: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(linkUp));
  // R8
  a_r8_fail_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
  // R9
  a_r9_fail_keeps_train: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (trainEn && !speedChgReq));
endmodule

bind link_speed_seq lss_checker #(.SPEED_W(SPEED_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .linkUp(linkUp),
  .speedBusy(speedBusy), .maxSpeed(maxSpeed), .trainEn(trainEn),
  .speedChgReq(speedChgReq), .done(done), .fail(fail)
);

// File: tb/tb_link_speed_seq.sv
module tb_link_speed_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NPOLL = 200;
  localparam int GAP   = 3;
  localparam int LAST1 = 1 + (NPOLL - 1) * (GAP + 1);
  localparam int LASTC = NPOLL * (GAP + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic linkUp = 1'b0;
  logic speedBusy = 1'b0;
  logic [31:0] linkStatus = '0;
  logic [3:0] maxSpeed;
  logic trainEn, speedChgReq, done, fail;
  logic [3:0] finalGen;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_speed_seq #(.MAX_POLLS(NPOLL), .POLL_GAP(GAP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .linkUp(linkUp),
    .speedBusy(speedBusy), .linkStatus(linkStatus), .maxSpeed(maxSpeed),
    .trainEn(trainEn), .speedChgReq(speedChgReq), .done(done),
    .fail(fail), .finalGen(finalGen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // waits at negedges until sig is 1; returns cycles waited
  task automatic waitReq(output int n);
    n = 0;
    while (!speedChgReq && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic waitEnd(output int n);
    n = 0;
    while (!done && !fail && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic tReset();
    chk("R1 maxSpeed", maxSpeed, 4'd1);
    chk("R1 trainEn", trainEn, 0);
    chk("R1 speedChgReq", speedChgReq, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 finalGen", finalGen, 0);
  endtask

  task automatic tLink1Timeout();
    linkUp = 0; speedBusy = 0;
    pulseStart();
    chk("R2 trainEn low after start", trainEn, 0);
    chk("R2 maxSpeed low", maxSpeed, 4'd1);
    @(negedge clk);
    chk("R2 trainEn rises", trainEn, 1);
    for (int k = 1; k <= LAST1; k++) begin
      @(negedge clk);
      if (k == LAST1 - 1) chk("R3 no fail before last poll", fail, 0);
    end
    chk("R3 fail at last poll", fail, 1);
    chk("R9 trainEn kept", trainEn, 1);
    chk("R9 maxSpeed held", maxSpeed, 4'd1);
    chk("R9 req low", speedChgReq, 0);
    repeat (10) @(negedge clk);
    chk("R8 fail sticky", fail, 1);
  endtask

  task automatic tStartIgnored();
    linkUp = 0;
    pulseStart();
    chk("R2 fail cleared by start", fail, 0);
    @(negedge clk);
    for (int k = 1; k <= LAST1; k++) begin
      @(negedge clk);
      if (k == 10) start = 1'b1;
      if (k == 11) start = 1'b0;
      if (k == LAST1 - 1) chk("R8 mid-run start ignored, no early fail", fail, 0);
    end
    chk("R8 mid-run start ignored, fail on time", fail, 1);
  endtask

  task automatic tLastPoll(input bit late);
    int n;
    linkUp = 0; speedBusy = 0; linkStatus = 32'h0002_0000;
    pulseStart();
    @(negedge clk);
    for (int k = 1; k <= LAST1; k++) begin
      @(negedge clk);
      if (!late && k == LAST1 - 1) linkUp = 1;
      if (late && k == LAST1) linkUp = 1;
    end
    if (late) begin
      chk("R3 link after last poll fails", fail, 1);
      chk("R3 speed stays low", maxSpeed, 4'd1);
    end else begin
      chk("R3 link on last poll accepted", fail, 0);
      chk("R4 maxSpeed raised", maxSpeed, 4'd2);
      chk("R4 req set", speedChgReq, 1);
      waitEnd(n);
      chk("R7 done", done, 1);
      chk("R7 finalGen", finalGen, 4'd2);
    end
    linkUp = 0;
  endtask

  task automatic tHappy();
    int n;
    linkUp = 1; speedBusy = 1; linkStatus = 32'hA5A3_FFFF;
    pulseStart();
    waitReq(n);
    chk("R4 req rises", speedChgReq, 1);
    for (int m = 1; m <= 5 * (GAP + 1); m++) @(negedge clk);
    chk("R5 req held while busy", speedChgReq, 1);
    chk("R5 no done while busy", done, 0);
    speedBusy = 0;
    waitEnd(n);
    chk("R5 req cleared", speedChgReq, 0);
    chk("R7 done set", done, 1);
    chk("R7 finalGen from bits 19:16", finalGen, 4'd3);
    chk("R10 no fail with done", fail, 0);
    repeat (8) @(negedge clk);
    chk("R8 done sticky", done, 1);
    linkUp = 0;
    pulseStart();
    chk("R8 start clears done", done, 0);
    chk("R2 maxSpeed back to 1", maxSpeed, 4'd1);
    waitEnd(n);
  endtask

  task automatic tChgTimeout();
    int n;
    linkUp = 1; speedBusy = 1;
    pulseStart();
    waitReq(n);
    for (int m = 1; m <= LASTC; m++) begin
      @(negedge clk);
      if (m == LASTC - 1) chk("R5 no fail before last busy poll", fail, 0);
    end
    chk("R5 fail on busy timeout", fail, 1);
    chk("R9 maxSpeed held at 2", maxSpeed, 4'd2);
    chk("R9 trainEn kept", trainEn, 1);
    chk("R9 req dropped", speedChgReq, 0);
    speedBusy = 0;
  endtask

  task automatic tLink2Fail();
    int n;
    linkUp = 1; speedBusy = 1;
    pulseStart();
    waitReq(n);
    linkUp = 0; speedBusy = 0;
    waitEnd(n);
    chk("R6 fail when link lost after change", fail, 1);
    chk("R6 no done", done, 0);
    chk("R9 maxSpeed 2", maxSpeed, 4'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLink1Timeout();
    tStartIgnored();
    tLastPoll(1'b0);
    tLastPoll(1'b1);
    tHappy();
    tChgTimeout();
    tLink2Fail();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule